// File: doc/BRIEF.md
# Three-Mode UART Baud-Rate Generator

This block turns a free-running source clock into the timing strobes a UART needs. A configuration register holds a main divisor A (16 bits), a secondary divisor B (4 bits) and two mode bits: an extended-divider enable and a divide-by-one select. The block emits a one-cycle bit-rate strobe. In the two prescaled modes it also emits a one-cycle sample strobe at the prescaler rate, which a receiver uses to oversample the line.

Three divider structures can be chosen. The default uses a fixed divide-by-16 prescaler ahead of the A stage. The extended mode replaces that prescaler with a programmable divide-by-(B+1) stage. The direct mode drops the prescaler entirely, so the A stage counts source clocks. A write to the configuration register restarts both counters at once, so the first strobe after a write always arrives one full period later. Some settings are illegal: B below 8 in the extended mode, or A below 3 in the direct mode. The block flags these and holds all strobes low while they are in place.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the block is in the divide-by-16 mode with A=0 and B=0. Both strobes and the error flag are low at the first sample after reset. The first sample strobe comes 16 cycles after the last reset edge and the first bit strobe comes 32 cycles after it.
- R2: With ext_en=0 (the divide-by-16 mode), bit_tick pulses every 16×(A+2) cycles and sample_tick pulses every 16 cycles, whatever value B holds.
- R3: With ext_en=1 and one_sel=0 (the divide-by-(B+1) mode, legal for B from 8 to 15), bit_tick pulses every (B+1)×(A+2) cycles and sample_tick pulses every B+1 cycles.
- R4: With ext_en=1 and one_sel=1 (the direct mode, legal for A of 3 or more), bit_tick pulses every A+2 cycles whatever value B holds, and sample_tick stays low.
- R5: When ext_en=0, one_sel has no effect: the divide-by-16 mode applies.
- R6: In the divide-by-(B+1) mode with B<8, cfg_err is high and both strobes stay low.
- R7: In the direct mode with A<3, cfg_err is high and both strobes stay low. A legal setting written afterwards clears cfg_err.
- R8: A write (cfg_wr high at a clock edge) restarts both counters at that edge. If P is the prescaler period (16 or B+1, and 1 in the direct mode), the first sample strobe comes P cycles after the write edge and the first bit strobe comes (A+2)×P cycles after it, even when the write repeats the current setting in the middle of a period.
- R9: Each strobe is high for exactly one cycle. In the prescaled modes every bit_tick coincides with a sample_tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cfg_div_a | input | 16 | Main divisor A |
| cfg_div_b | input | 4 | Secondary divisor B |
| cfg_ext_en | input | 1 | Extended-divider enable |
| cfg_one_sel | input | 1 | Divide-by-one select (only used when ext_en=1) |
| bit_tick | output | 1 | One-cycle bit-rate strobe |
| sample_tick | output | 1 | One-cycle prescaler-rate strobe (prescaled modes only) |
| cfg_err | output | 1 | Illegal-configuration flag |

## Verification
Each mode is run with several A and B values. Measuring both the offset of the first strobe from the write edge and the spacing to the second strobe separates an off-by-one in the reload value from an off-by-one in the prescaler limit. A nonzero B in the divide-by-16 mode and a zero B in the direct mode show whether B leaks into modes that must ignore it. A mode-2 encoding with ext_en low tells apart a decoder that honours the enable from one that reads only one_sel. The legal and illegal sides of both minimum-value rules (B=7 against B=8, A=2 against A=3) are each tried, and a mid-period rewrite of the same setting shows whether the counters truly restart.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  typedef enum logic [1:0] {
    MODE_X16 = 2'd0,
    MODE_XB  = 2'd1,
    MODE_X1  = 2'd2
  } div_mode_e;

  function automatic div_mode_e decode_mode(input logic ext_en, input logic one_sel);
    if (!ext_en)      return MODE_X16;
    else if (one_sel) return MODE_X1;
    else              return MODE_XB;
  endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_gen_pkg::*;
#(
  parameter int A_W      = 16,
  parameter int B_W      = 4,
  parameter int B_MIN    = 8,
  parameter int A_MIN_X1 = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           ext_in,
  input  logic           one_in,
  output logic [A_W-1:0] a_q,
  output logic [B_W-1:0] b_q,
  output div_mode_e      mode_q,
  output logic           err_q
);

  div_mode_e mode_nx;
  logic      err_nx;

  always_comb begin
    mode_nx = decode_mode(ext_in, one_in);
    err_nx  = 1'b0;
    if (mode_nx == MODE_XB && b_in < B_W'(B_MIN))    err_nx = 1'b1;
    if (mode_nx == MODE_X1 && a_in < A_W'(A_MIN_X1)) err_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q    <= '0;
      b_q    <= '0;
      mode_q <= MODE_X16;
      err_q  <= 1'b0;
    end else if (wr) begin
      a_q    <= a_in;
      b_q    <= b_in;
      mode_q <= mode_nx;
      err_q  <= err_nx;
    end
  end

  AST_ERR_LEGAL_X16: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_X16) |-> !err_q); // R5

  AST_MODE_VALID: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'd3); // R5

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
  import baud_gen_pkg::*;
#(
  parameter int B_W     = 4,
  parameter int FIX_PRE = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  div_mode_e      mode,
  input  logic [B_W-1:0] b_q,
  output logic           evt
);

  localparam int FIX_W = $clog2(FIX_PRE);
  localparam int PW    = (FIX_W > B_W) ? FIX_W : B_W;

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  always_comb begin
    case (mode)
      MODE_X16: lim = PW'(FIX_PRE - 1);
      MODE_XB:  lim = PW'(b_q);
      default:  lim = '0;
    endcase
    evt = (mode == MODE_X1) ? 1'b1 : (cnt == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart)        cnt <= '0;
    else if (mode == MODE_X1)  cnt <= '0;
    else if (cnt == lim)       cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  AST_PCNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim); // R8

endmodule

// File: rtl/baud_a_stage.sv
module baud_a_stage #(
  parameter int A_W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           restart,
  input  logic [A_W-1:0] reload_in,
  input  logic [A_W-1:0] a_q,
  input  logic           evt,
  output logic           a_evt
);

  localparam int CW = A_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] top_q;

  assign top_q = {1'b0, a_q} + CW'(1);
  assign a_evt = evt && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt <= CW'(1);
    else if (restart) cnt <= {1'b0, reload_in} + CW'(1);
    else if (evt) begin
      if (cnt == '0)  cnt <= top_q;
      else            cnt <= cnt - 1'b1;
    end
  end

  AST_ACNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= top_q); // R8

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_gen_pkg::*;
#(
  parameter int A_W      = 16,
  parameter int B_W      = 4,
  parameter int FIX_PRE  = 16,
  parameter int B_MIN    = 8,
  parameter int A_MIN_X1 = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_wr,
  input  logic [15:0]    cfg_div_a,
  input  logic [3:0]     cfg_div_b,
  input  logic           cfg_ext_en,
  input  logic           cfg_one_sel,
  output logic           bit_tick,
  output logic           sample_tick,
  output logic           cfg_err
);

  logic [A_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  div_mode_e      mode_q;
  logic           err_q;
  logic           pre_evt;
  logic           a_evt;
  logic           bit_q;
  logic           samp_q;

  baud_cfg_reg #(
    .A_W(A_W), .B_W(B_W), .B_MIN(B_MIN), .A_MIN_X1(A_MIN_X1)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr),
    .a_in(A_W'(cfg_div_a)), .b_in(B_W'(cfg_div_b)),
    .ext_in(cfg_ext_en), .one_in(cfg_one_sel),
    .a_q(a_q), .b_q(b_q), .mode_q(mode_q), .err_q(err_q)
  );

  baud_prescaler #(
    .B_W(B_W), .FIX_PRE(FIX_PRE)
  ) u_pre (
    .clk(clk), .rst(rst), .restart(cfg_wr),
    .mode(mode_q), .b_q(b_q), .evt(pre_evt)
  );

  baud_a_stage #(
    .A_W(A_W)
  ) u_astage (
    .clk(clk), .rst(rst), .restart(cfg_wr),
    .reload_in(A_W'(cfg_div_a)), .a_q(a_q),
    .evt(pre_evt), .a_evt(a_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      bit_q  <= a_evt && !err_q && !cfg_wr;
      samp_q <= pre_evt && (mode_q != MODE_X1) && !err_q && !cfg_wr;
    end
  end

  assign bit_tick    = bit_q;
  assign sample_tick = samp_q;
  assign cfg_err     = err_q;

  AST_ERR_SILENCES: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (!bit_tick && !sample_tick)); // R6

  AST_NO_SAMPLE_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_X1) |-> !sample_tick); // R4

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (bit_tick && mode_q != MODE_X1) |-> sample_tick); // R9

  AST_BIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R9

  AST_SAMPLE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick); // R9

endmodule

// File: tb/baud_tick_gen_test.sv
module baud_tick_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [15:0] cfg_div_a = '0;
  logic [3:0]  cfg_div_b = '0;
  logic        cfg_ext_en = 1'b0;
  logic        cfg_one_sel = 1'b0;
  logic        bit_tick;
  logic        sample_tick;
  logic        cfg_err;

  int n_run  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  baud_tick_gen uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr),
    .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b),
    .cfg_ext_en(cfg_ext_en), .cfg_one_sel(cfg_one_sel),
    .bit_tick(bit_tick), .sample_tick(sample_tick), .cfg_err(cfg_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Write lands at the posedge between the two negedges; returns at the
  // negedge after the write edge (offset 0).
  task automatic do_write(input logic [15:0] a, input logic [3:0] b,
                          input logic ext, input logic one);
    @(negedge clk);
    cfg_div_a = a; cfg_div_b = b; cfg_ext_en = ext; cfg_one_sel = one;
    cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Observe from offset 0; records strobe offsets and shape violations.
  task automatic observe(input string tag, input int exp_bit, input int exp_samp);
    int fb = -1, sb = -1, fs = -1, ss = -1, wide = 0, misalign = 0, nsamp = 0;
    logic prev_b = bit_tick, prev_s = sample_tick;
    for (int k = 1; k <= 2 * exp_bit + 1; k++) begin
      @(negedge clk);
      if (bit_tick) begin
        if (fb < 0) fb = k; else if (sb < 0) sb = k;
        if (exp_samp != 0 && !sample_tick) misalign++;
      end
      if (sample_tick) begin
        nsamp++;
        if (fs < 0) fs = k; else if (ss < 0) ss = k;
      end
      if ((bit_tick && prev_b) || (sample_tick && prev_s)) wide++;
      prev_b = bit_tick; prev_s = sample_tick;
    end
    check({tag, " R8 first bit offset"}, fb, exp_bit);
    check({tag, " bit period"}, sb - fb, exp_bit);
    if (exp_samp != 0) begin
      check({tag, " R8 first sample offset"}, fs, exp_samp);
      check({tag, " sample period"}, ss - fs, exp_samp);
      check({tag, " R9 bit on sample"}, misalign, 0);
    end else begin
      check({tag, " R4 no sample strobe"}, nsamp, 0);
    end
    check({tag, " R9 one-cycle strobes"}, wide, 0);
    check({tag, " no error"}, int'(cfg_err), 0);
  endtask

  task automatic run_case(input string tag, input logic [15:0] a, input logic [3:0] b,
                          input logic ext, input logic one,
                          input int exp_bit, input int exp_samp);
    do_write(a, b, ext, one);
    observe(tag, exp_bit, exp_samp);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 bit_tick at reset", int'(bit_tick), 0);
    check("R1 sample_tick at reset", int'(sample_tick), 0);
    check("R1 cfg_err at reset", int'(cfg_err), 0);
    observe("R1 default", 32, 16);
  endtask

  task automatic test_mode0();
    run_case("R2 x16 A=0 B=0", 16'd0, 4'd0, 1'b0, 1'b0, 32, 16);
    run_case("R2 x16 A=3 B=11 ignored", 16'd3, 4'd11, 1'b0, 1'b0, 80, 16);
    run_case("R5 ext=0 one=1 stays x16", 16'd1, 4'd9, 1'b0, 1'b1, 48, 16);
  endtask

  task automatic test_mode1();
    run_case("R3 xB A=1 B=9", 16'd1, 4'd9, 1'b1, 1'b0, 30, 10);
    run_case("R3 xB A=0 B=8 min", 16'd0, 4'd8, 1'b1, 1'b0, 18, 9);
    run_case("R3 xB A=10 B=15 max", 16'd10, 4'd15, 1'b1, 1'b0, 192, 16);
  endtask

  task automatic test_mode2();
    run_case("R4 x1 A=3 B=0 min", 16'd3, 4'd0, 1'b1, 1'b1, 5, 0);
    run_case("R4 x1 A=40 B=12", 16'd40, 4'd12, 1'b1, 1'b1, 42, 0);
  endtask

  task automatic check_illegal(input string tag, input logic [15:0] a, input logic [3:0] b,
                               input logic one, input int window);
    int strobes = 0;
    do_write(a, b, 1'b1, one);
    for (int k = 1; k <= window; k++) begin
      @(negedge clk);
      if (bit_tick || sample_tick) strobes++;
    end
    check({tag, " cfg_err"}, int'(cfg_err), 1);
    check({tag, " strobes held low"}, strobes, 0);
  endtask

  task automatic test_errors();
    check_illegal("R6 xB B=7", 16'd0, 4'd7, 1'b0, 100);
    check_illegal("R6 xB B=0", 16'd2, 4'd0, 1'b0, 100);
    run_case("R6 recover B=8", 16'd0, 4'd8, 1'b1, 1'b0, 18, 9);
    check_illegal("R7 x1 A=2", 16'd2, 4'd9, 1'b1, 100);
    run_case("R7 recover A=3", 16'd3, 4'd9, 1'b1, 1'b1, 5, 0);
  endtask

  task automatic test_restart();
    do_write(16'd1, 4'd0, 1'b0, 1'b0);
    repeat (20) @(negedge clk);
    run_case("R8 rewrite mid-period x16", 16'd1, 4'd0, 1'b0, 1'b0, 48, 16);
    repeat (13) @(negedge clk);
    run_case("R8 rewrite mid-period x1", 16'd7, 4'd0, 1'b1, 1'b1, 9, 0);
  endtask

  initial begin
    test_reset();
    test_mode0();
    test_mode1();
    test_mode2();
    test_errors();
    test_restart();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000 && !done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule